// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

This block measures the period of two external signals against one shared free-running 16-bit counter. Each channel watches its own asynchronous input. The input is resynchronised, and then an edge detector picks out rising edges, falling edges or both. When the channel's capture enable is set and a selected edge is seen, the channel stores the counter value. It also produces the difference from the previous stored value, which is the signal period in clock ticks. A one-cycle interrupt strobe follows each capture.

The outputs are plain status signals with no back-pressure. Each capture value, period and valid flag is a register that holds until the channel's next capture. No consumer can stall the block. A reader that misses an interrupt strobe sees a later capture overwrite the earlier one. The two channels share only the counter and are otherwise independent.

Top module: `capt_timer`

## Requirements
- R1: The counter is CNT_W (16) bits wide. It is zero in reset and adds one on every clock edge after reset is released, wrapping from 16'hFFFF to 0. The value captured is the count the counter held just before the capturing edge.
- R2: Each channel c has a two-bit edge mode at `edge_sel[2c+1:2c]` with these codes: 2'b00 never captures, 2'b01 captures on a low-to-high change, 2'b10 captures on a high-to-low change, and 2'b11 captures on either change.
- R3: A channel captures only while its `cap_en` bit is high at the capturing edge. While the bit is low, that channel's `cap_val` and `period` do not change.
- R4: If a pin level is first sampled at clock edge k, the capture caused by that change happens at edge k+2. The counter value stored is the one held just before edge k+2.
- R5: Each capture raises that channel's `irq` bit for exactly one cycle, beginning one clock edge after `cap_val` updates. `irq` never rises unless `cap_en` was high two edges earlier.
- R6: On each capture, `period` becomes the new capture value minus the previous capture value, modulo 2^16. The result is therefore correct across one counter wrap.
- R7: `period_valid` rises on the second capture after reset or after `cap_en` goes high. It is cleared on the edge after `cap_en` is sampled low.
- R8: Activity on one channel has no effect on the other channel's outputs.
- R9: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | NUM_CH | Asynchronous measured inputs, one bit per channel |
| edge_sel | input | 2*NUM_CH | Edge mode per channel, two bits each |
| cap_en | input | NUM_CH | Capture enable per channel |
| cap_val | output | CNT_W*NUM_CH | Last captured count per channel |
| period | output | CNT_W*NUM_CH | Difference of the last two captures per channel |
| period_valid | output | NUM_CH | Period is meaningful, per channel |
| irq | output | NUM_CH | One-cycle capture strobe per channel |

## Verification
Both channels run square waves of different lengths at the same time, first on rising edges only and then on falling edges only. This separates the edge polarities and shows that each period is computed per channel. Switching to both-edge mode with a shorter toggle interval gives a half-period result, so that mode cannot be mistaken for a single-edge mode. A single hand-timed step on an idle pin fixes the exact latency and the cycle in which the strobe appears. A mode-off window and an enable-off window show that capturing stops and the valid flag clears. A run longer than 65536 cycles with a steady wave shows that the modular period survives counter wraps.

// File: rtl/capt_pkg.sv
package capt_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/capt_counter.sv
module capt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end
endmodule

// File: rtl/capt_sync.sv
module capt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  // STAGES flops of metastability filtering plus one history flop
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], d};
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/capt_channel.sv
module capt_channel
  import capt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  edge_mode_e       mode,
  input  logic             en,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_q,
  output logic [CNT_W-1:0] period_q,
  output logic             valid_q,
  output logic             irq_q
);
  logic lvl, lvl_prev, rise, fall, sel_hit, hit;
  logic have_one, hit_r;

  capt_sync #(.STAGES(STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(lvl), .q_prev(lvl_prev)
  );

  assign rise = lvl & ~lvl_prev;
  assign fall = ~lvl & lvl_prev;

  always_comb begin
    unique case (mode)
      EDGE_OFF:  sel_hit = 1'b0;
      EDGE_RISE: sel_hit = rise;
      EDGE_FALL: sel_hit = fall;
      EDGE_ANY:  sel_hit = rise | fall;
      default:   sel_hit = 1'b0;
    endcase
  end

  assign hit = en & sel_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q    <= '0;
      period_q <= '0;
      valid_q  <= 1'b0;
      have_one <= 1'b0;
      hit_r    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      hit_r <= hit;
      irq_q <= hit_r;
      if (!en) begin
        have_one <= 1'b0;
        valid_q  <= 1'b0;
      end else if (hit) begin
        cap_q    <= count;
        period_q <= count - cap_q;
        have_one <= 1'b1;
        valid_q  <= have_one;
      end
    end
  end
endmodule

// File: rtl/capt_timer.sv
module capt_timer
  import capt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       cap_pin,
  input  logic [2*NUM_CH-1:0]     edge_sel,
  input  logic [NUM_CH-1:0]       cap_en,
  output logic [CNT_W*NUM_CH-1:0] cap_val,
  output logic [CNT_W*NUM_CH-1:0] period,
  output logic [NUM_CH-1:0]       period_valid,
  output logic [NUM_CH-1:0]       irq
);
  logic [CNT_W-1:0] count;

  capt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .count(count)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    capt_channel #(.CNT_W(CNT_W), .STAGES(STAGES)) ch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (cap_pin[c]),
      .mode     (edge_mode_e'(edge_sel[2*c +: 2])),
      .en       (cap_en[c]),
      .count    (count),
      .cap_q    (cap_val[CNT_W*c +: CNT_W]),
      .period_q (period[CNT_W*c +: CNT_W]),
      .valid_q  (period_valid[c]),
      .irq_q    (irq[c])
    );
  end
endmodule

// File: rtl/capt_timer_chk.sv
module capt_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2*NUM_CH-1:0]     edge_sel,
  input logic [NUM_CH-1:0]       cap_en,
  input logic [CNT_W*NUM_CH-1:0] cap_val,
  input logic [CNT_W*NUM_CH-1:0] period,
  input logic [NUM_CH-1:0]       period_valid,
  input logic [NUM_CH-1:0]       irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R3
    en_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en[c] |=> $stable(cap_val[CNT_W*c +: CNT_W]) && $stable(period[CNT_W*c +: CNT_W]));
    // R2
    mode_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[2*c +: 2] == 2'b00) |=> $stable(cap_val[CNT_W*c +: CNT_W]));
    // R7
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en[c] |=> !period_valid[c]);
    // R5
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> $past(cap_en[c], 2));
    // R6
    period_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (period_valid[c] && !$stable(cap_val[CNT_W*c +: CNT_W])) |->
        (period[CNT_W*c +: CNT_W] ==
         CNT_W'(cap_val[CNT_W*c +: CNT_W] - $past(cap_val[CNT_W*c +: CNT_W]))));
  end
endmodule

bind capt_timer capt_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .edge_sel(edge_sel), .cap_en(cap_en),
  .cap_val(cap_val), .period(period), .period_valid(period_valid), .irq(irq)
);

// File: tb/capt_timer_tb_top.sv
`timescale 1ns/1ps
module capt_timer_tb_top;
  localparam int W = 16;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]     cap_pin = '0;
  logic [2*N-1:0]   edge_sel = '0;
  logic [N-1:0]     cap_en = '0;
  logic [W*N-1:0]   cap_val, period;
  logic [N-1:0]     period_valid, irq;

  int tests = 0, fails = 0;
  bit done = 0;
  int tog [N];
  int ph  [N];
  int cyc = 0;

  always #4 clk = ~clk;

  capt_timer #(.CNT_W(W), .NUM_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .edge_sel(edge_sel),
    .cap_en(cap_en), .cap_val(cap_val), .period(period),
    .period_valid(period_valid), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] cv(input int c);
    return cap_val[W*c +: W];
  endfunction
  function automatic logic [W-1:0] pv(input int c);
    return period[W*c +: W];
  endfunction

  // reference model
  bit         hq [N][$];
  logic [W-1:0] m_cnt;
  logic [W-1:0] m_cap [N];
  logic [W-1:0] m_per [N];
  bit m_val [N], m_have [N], m_irq [N], m_pend [N];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0;
      for (int c = 0; c < N; c++) begin
        hq[c] = '{0, 0, 0, 0};
        m_cap[c] = '0; m_per[c] = '0;
        m_val[c] = 0; m_have[c] = 0; m_irq[c] = 0; m_pend[c] = 0;
      end
    end else begin
      cyc++;
      for (int c = 0; c < N; c++) begin
        bit nw, od, hit;
        int sz;
        hq[c].push_back(cap_pin[c]);
        sz = hq[c].size();
        nw = hq[c][sz-3];
        od = hq[c][sz-4];
        case (edge_sel[2*c +: 2])
          2'b01:   hit = nw && !od;
          2'b10:   hit = !nw && od;
          2'b11:   hit = nw != od;
          default: hit = 0;
        endcase
        hit = hit && cap_en[c];
        m_irq[c] = m_pend[c];
        m_pend[c] = hit;
        if (!cap_en[c]) begin
          m_have[c] = 0; m_val[c] = 0;
        end else if (hit) begin
          m_per[c] = m_cnt - m_cap[c];
          m_cap[c] = m_cnt;
          m_val[c] = m_have[c];
          m_have[c] = 1;
        end
        while (hq[c].size() > 4) void'(hq[c].pop_front());
      end
      m_cnt = m_cnt + 1'b1;
    end
  end

  // pin stimulus: toggle every tog[c] cycles when tog[c] > 0
  always @(negedge clk) begin
    for (int c = 0; c < N; c++) begin
      if (tog[c] > 0) begin
        ph[c]++;
        if (ph[c] >= tog[c]) begin
          ph[c] = 0;
          cap_pin[c] = ~cap_pin[c];
        end
      end
    end
  end

  // per-cycle comparison against the model (R1 R2 R3 R5 R6 R7 R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < N; c++) begin
        chk(cv(c) == m_cap[c], "R1", "cap_val", cv(c), m_cap[c]);
        chk(pv(c) == m_per[c], "R6", "period", pv(c), m_per[c]);
        chk(period_valid[c] == m_val[c], "R7", "period_valid", period_valid[c], m_val[c]);
        chk(irq[c] == m_irq[c], "R5", "irq", irq[c], m_irq[c]);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] held;
    int v;
    tog[0] = 0; tog[1] = 0; ph[0] = 0; ph[1] = 0;
    wait_cyc(5);
    // R9 reset state
    chk(cap_val == '0 && period == '0, "R9", "data in reset", cap_val, 0);
    chk(period_valid == '0 && irq == '0, "R9", "flags in reset", {period_valid, irq}, 0);
    rst_n = 1'b1;

    // R2 R8: ch0 rising every 40, ch1 falling every 54
    cap_en = 2'b11; edge_sel = {2'b10, 2'b01};
    tog[0] = 20; tog[1] = 27;
    wait_cyc(400);
    chk(pv(0) == 40 && period_valid[0], "R2", "ch0 rising period", pv(0), 40);
    chk(pv(1) == 54 && period_valid[1], "R8", "ch1 falling period", pv(1), 54);

    // R2 both edges: half period
    edge_sel[1:0] = 2'b11; tog[0] = 15;
    wait_cyc(300);
    chk(pv(0) == 15, "R2", "ch0 both-edge period", pv(0), 15);
    chk(pv(1) == 54, "R8", "ch1 unaffected", pv(1), 54);

    // R2 mode off holds
    edge_sel[3:2] = 2'b00; wait_cyc(2); held = cv(1);
    wait_cyc(300);
    chk(cv(1) == held, "R2", "ch1 off holds capture", cv(1), held);

    // R3 R7 enable low
    cap_en[0] = 1'b0; wait_cyc(2); held = cv(0);
    chk(!period_valid[0], "R7", "valid cleared", period_valid[0], 0);
    wait_cyc(200);
    chk(cv(0) == held, "R3", "ch0 disabled holds", cv(0), held);
    cap_en[0] = 1'b1;
    wait_cyc(200);
    chk(period_valid[0] && pv(0) == 15, "R7", "valid back after two captures", pv(0), 15);

    // R4 R5 exact latency on idle ch1
    tog[1] = 0; cap_pin[1] = 1'b0; edge_sel[3:2] = 2'b01;
    wait_cyc(10);
    v = cyc;
    cap_pin[1] = 1'b1;
    wait_cyc(3);
    chk(cv(1) == W'(v + 2), "R4", "capture latency", cv(1), W'(v + 2));
    chk(irq[1] == 1'b0, "R5", "irq not yet", irq[1], 0);
    wait_cyc(1);
    chk(irq[1] == 1'b1, "R5", "irq pulse", irq[1], 1);
    wait_cyc(1);
    chk(irq[1] == 1'b0, "R5", "irq one cycle", irq[1], 0);

    // R1 R6 across counter wraps
    edge_sel[1:0] = 2'b01; tog[0] = 500;
    wait_cyc(70000);
    chk(pv(0) == 1000 && period_valid[0], "R6", "period across wrap", pv(0), 1000);
    chk(cyc > 65536, "R1", "counter wrapped", cyc, 65537);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule